// File: doc/BRIEF.md
# Dual-Pipe In-Order Issue Gate

This block sits between an instruction decode queue and two execution pipes. Each cycle it looks at the two oldest decoded instructions. The older one is always presented on slot 0 and the younger one on slot 1. The block decides whether none, one or both of them leave for execution. Slot 0 feeds pipe0 and slot 1 feeds pipe1. The block returns a grant per pipe and a count of consumed instructions, and the upstream queue advances by that count.

Register readiness is predicted rather than signalled. A scoreboard keeps one down-counter per architectural register. When an instruction issues, the counter for its destination is loaded with the instruction's fixed result latency. Every counter then counts down by one each cycle. A source counts as ready once its counter has fallen to the forwarding level. Issue is strictly in order: the younger instruction never leaves ahead of the older one. Only pipe0 has a multiplier, and the pair shares a single address-generation unit for memory operations.

A flush clears every pending scoreboard entry and withholds all grants in that cycle. Because results are written only at the end of the pipes, no write-after-read check is needed.

Top module: `pair_issue_ctl`

## Requirements
- R1: When both slots are valid, independent, hazard-free and structurally compatible, `grant0` and `grant1` are both 1 in the same cycle.
- R2: `grant1` is never 1 in a cycle where `grant0` is 0. This includes cycles where slot 0 is not valid.
- R3: An instruction whose enabled source register has a scoreboard counter above `FWD_LEVEL` (default 1) is not granted. On issue, a register's counter is loaded with the issuer's latency, and it drops by one per cycle down to 0. A source whose enable bit is 0 is never checked.
- R4: An instruction with an enabled destination is not granted while that register's counter is greater than or equal to the instruction's own latency.
- R5: An instruction of class multiply (`cls` = 2'b01) is never granted on slot 1.
- R6: Two load/store instructions (`cls` = 2'b10) are not granted together. A load/store on slot 0 paired with an ALU instruction (`cls` = 2'b00) on slot 1 may issue as a pair.
- R7: If slot 0 writes a register (destination enable 1) and slot 1 reads it through an enabled source or writes it, only slot 0 is granted. If slot 0's destination enable is 0, there is no such restriction.
- R8: While `flush` is 1, both grants are 0. On the next cycle every scoreboard counter is 0, so any source is ready.
- R9: `consumed` equals the number of grants given in that cycle: 0, 1 or 2.
- R10: After reset every register is ready, so an instruction that reads any register issues immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard pending scoreboard state and hold issue |
| s0_vld | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 2 | Slot 0 class: 00 ALU, 01 multiply, 10 load/store |
| s0_dst | input | RIDX_W | Slot 0 destination register |
| s0_dst_en | input | 1 | Slot 0 writes a register |
| s0_srca | input | RIDX_W | Slot 0 first source register |
| s0_srca_en | input | 1 | Slot 0 first source in use |
| s0_srcb | input | RIDX_W | Slot 0 second source register |
| s0_srcb_en | input | 1 | Slot 0 second source in use |
| s0_lat | input | LAT_W | Slot 0 result latency in cycles |
| s1_vld | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 2 | Slot 1 class |
| s1_dst | input | RIDX_W | Slot 1 destination register |
| s1_dst_en | input | 1 | Slot 1 writes a register |
| s1_srca | input | RIDX_W | Slot 1 first source register |
| s1_srca_en | input | 1 | Slot 1 first source in use |
| s1_srcb | input | RIDX_W | Slot 1 second source register |
| s1_srcb_en | input | 1 | Slot 1 second source in use |
| s1_lat | input | LAT_W | Slot 1 result latency in cycles |
| grant0 | output | 1 | Slot 0 instruction issues to pipe0 this cycle |
| grant1 | output | 1 | Slot 1 instruction issues to pipe1 this cycle |
| consumed | output | 2 | Number of instructions taken from the queue |

## Verification
The assertions assume that every valid instruction with a destination carries a latency of at least 1. A latency of 0 would break the write-after-write comparison and the counter semantics. They also assume that slot fields are meaningful only when the matching valid bit is set. The stimulus only ever drives latencies from 1 to 7. It leaves invalid slots at zero or with harmless values, and it deasserts reset only on a falling clock edge. With those inputs, the cross-module properties must hold in every cycle. These properties cover distinct destinations for a granted pair, readiness of the sources that were granted, and counters cleared after a flush.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

   typedef enum logic [1:0] {
      CLS_ALU = 2'b00,
      CLS_MUL = 2'b01,
      CLS_LS  = 2'b10
   } op_class_e;

   localparam int SLOTS = 2;

endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
   parameter int NREG   = 16,
   parameter int LAT_W  = 3,
   localparam int RIDX_W = $clog2(NREG)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            ld0,
   input  logic [RIDX_W-1:0]               ld0_reg,
   input  logic [LAT_W-1:0]                ld0_lat,
   input  logic                            ld1,
   input  logic [RIDX_W-1:0]               ld1_reg,
   input  logic [LAT_W-1:0]                ld1_lat,
   output logic [NREG-1:0][LAT_W-1:0]      cnt_o
);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit0, hit1;
      assign hit0 = ld0 && (ld0_reg == RIDX_W'(r));
      assign hit1 = ld1 && (ld1_reg == RIDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_o[r] <= '0;
         else if (flush)
            cnt_o[r] <= '0;
         else if (hit0)
            cnt_o[r] <= ld0_lat;
         else if (hit1)
            cnt_o[r] <= ld1_lat;
         else if (cnt_o[r] != '0)
            cnt_o[r] <= cnt_o[r] - 1'b1;
      end
   end

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_o == '0));

   // R7
   distinct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld0 && ld1) |-> (ld0_reg != ld1_reg));

endmodule

// File: rtl/slot_hazard.sv
module slot_hazard #(
   parameter int NREG      = 16,
   parameter int LAT_W     = 3,
   parameter int FWD_LEVEL = 1,
   localparam int RIDX_W   = $clog2(NREG)
) (
   input  logic [NREG-1:0][LAT_W-1:0] cnt_i,
   input  logic                       srca_en,
   input  logic [RIDX_W-1:0]          srca,
   input  logic                       srcb_en,
   input  logic [RIDX_W-1:0]          srcb,
   input  logic                       dst_en,
   input  logic [RIDX_W-1:0]          dst,
   input  logic [LAT_W-1:0]           lat,
   output logic                       raw_clr,
   output logic                       waw_clr
);

   localparam logic [LAT_W-1:0] FWD = LAT_W'(FWD_LEVEL);

   logic a_rdy, b_rdy;

   if (FWD_LEVEL == 0) begin : g_exact
      assign a_rdy = (cnt_i[srca] == '0);
      assign b_rdy = (cnt_i[srcb] == '0);
   end else begin : g_fwd
      assign a_rdy = (cnt_i[srca] <= FWD);
      assign b_rdy = (cnt_i[srcb] <= FWD);
   end

   assign raw_clr = (!srca_en || a_rdy) && (!srcb_en || b_rdy);
   assign waw_clr = !dst_en || (cnt_i[dst] < lat);

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
   import pair_issue_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int LAT_W     = 3,
   parameter int FWD_LEVEL = 1,
   localparam int RIDX_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              s0_vld,
   input  logic [1:0]        s0_cls,
   input  logic [RIDX_W-1:0] s0_dst,
   input  logic              s0_dst_en,
   input  logic [RIDX_W-1:0] s0_srca,
   input  logic              s0_srca_en,
   input  logic [RIDX_W-1:0] s0_srcb,
   input  logic              s0_srcb_en,
   input  logic [LAT_W-1:0]  s0_lat,
   input  logic              s1_vld,
   input  logic [1:0]        s1_cls,
   input  logic [RIDX_W-1:0] s1_dst,
   input  logic              s1_dst_en,
   input  logic [RIDX_W-1:0] s1_srca,
   input  logic              s1_srca_en,
   input  logic [RIDX_W-1:0] s1_srcb,
   input  logic              s1_srcb_en,
   input  logic [LAT_W-1:0]  s1_lat,
   output logic              grant0,
   output logic              grant1,
   output logic [1:0]        consumed
);

   if (NREG < 2 || NREG != (1 << RIDX_W)) begin : g_bad_nreg
      $error("pair_issue_ctl: NREG must be a power of two of at least 2");
   end
   if (LAT_W < 2) begin : g_bad_latw
      $error("pair_issue_ctl: LAT_W must be at least 2");
   end
   if (FWD_LEVEL < 0 || FWD_LEVEL >= (1 << LAT_W)) begin : g_bad_fwd
      $error("pair_issue_ctl: FWD_LEVEL out of counter range");
   end

   logic [NREG-1:0][LAT_W-1:0] sb_cnt;

   logic [SLOTS-1:0]             v_srca_en, v_srcb_en, v_dst_en;
   logic [SLOTS-1:0][RIDX_W-1:0] v_srca, v_srcb, v_dst;
   logic [SLOTS-1:0][LAT_W-1:0]  v_lat;
   logic [SLOTS-1:0]             raw_ok, waw_ok;

   assign v_srca_en = {s1_srca_en, s0_srca_en};
   assign v_srcb_en = {s1_srcb_en, s0_srcb_en};
   assign v_dst_en  = {s1_dst_en,  s0_dst_en};
   assign v_srca    = {s1_srca, s0_srca};
   assign v_srcb    = {s1_srcb, s0_srcb};
   assign v_dst     = {s1_dst,  s0_dst};
   assign v_lat     = {s1_lat,  s0_lat};

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      slot_hazard #(
         .NREG      (NREG),
         .LAT_W     (LAT_W),
         .FWD_LEVEL (FWD_LEVEL)
      ) u_hz (
         .cnt_i   (sb_cnt),
         .srca_en (v_srca_en[s]),
         .srca    (v_srca[s]),
         .srcb_en (v_srcb_en[s]),
         .srcb    (v_srcb[s]),
         .dst_en  (v_dst_en[s]),
         .dst     (v_dst[s]),
         .lat     (v_lat[s]),
         .raw_clr (raw_ok[s]),
         .waw_clr (waw_ok[s])
      );
   end

   logic pair_dep, pair_struct_ok, go0, go1;

   assign pair_dep = s0_dst_en &&
                     ((s1_srca_en && (s1_srca == s0_dst)) ||
                      (s1_srcb_en && (s1_srcb == s0_dst)) ||
                      (s1_dst_en  && (s1_dst  == s0_dst)));

   assign pair_struct_ok = (s1_cls != CLS_MUL) &&
                           !((s0_cls == CLS_LS) && (s1_cls == CLS_LS));

   assign go0 = !flush && s0_vld && raw_ok[0] && waw_ok[0];
   assign go1 = go0 && s1_vld && raw_ok[1] && waw_ok[1] &&
                pair_struct_ok && !pair_dep;

   assign grant0   = go0;
   assign grant1   = go1;
   assign consumed = 2'(go0) + 2'(go1);

   issue_scoreboard #(
      .NREG  (NREG),
      .LAT_W (LAT_W)
   ) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .ld0     (go0 && s0_dst_en),
      .ld0_reg (s0_dst),
      .ld0_lat (s0_lat),
      .ld1     (go1 && s1_dst_en),
      .ld1_reg (s1_dst),
      .ld1_lat (s1_lat),
      .cnt_o   (sb_cnt)
   );

   // R2
   pipe1_needs_pipe0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant1 |-> grant0);

   // R5
   mul_pipe0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant1 |-> (s1_cls != CLS_MUL));

   // R6
   single_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant0 && grant1) |-> !((s0_cls == CLS_LS) && (s1_cls == CLS_LS)));

   // R8
   flush_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!grant0 && !grant1));

   // R3
   src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant0 && s0_srca_en) |-> (sb_cnt[s0_srca] <= LAT_W'(FWD_LEVEL)));

   // R4
   waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant0 && s0_dst_en) |-> (sb_cnt[s0_dst] < s0_lat));

   // R9
   consumed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      consumed != 2'd3);

endmodule

// File: tb/pair_issue_ctl_tb.sv
`timescale 1ns/1ps
module pair_issue_ctl_tb;

   localparam int NR = 16;

   typedef struct {
      bit       vld;
      bit [1:0] cls;
      bit [3:0] dst;
      bit       de;
      bit [3:0] sa;
      bit       ae;
      bit [3:0] sb;
      bit       be;
      bit [2:0] lat;
   } desc_t;

   typedef struct {
      bit    g0;
      bit    g1;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic s0_vld = 0, s0_dst_en = 0, s0_srca_en = 0, s0_srcb_en = 0;
   logic s1_vld = 0, s1_dst_en = 0, s1_srca_en = 0, s1_srcb_en = 0;
   logic [1:0] s0_cls = 0, s1_cls = 0;
   logic [3:0] s0_dst = 0, s0_srca = 0, s0_srcb = 0;
   logic [3:0] s1_dst = 0, s1_srca = 0, s1_srcb = 0;
   logic [2:0] s0_lat = 0, s1_lat = 0;
   logic grant0, grant1;
   logic [1:0] consumed;

   always #4 clk = ~clk;

   pair_issue_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_dst_en(s0_dst_en),
      .s0_srca(s0_srca), .s0_srca_en(s0_srca_en), .s0_srcb(s0_srcb),
      .s0_srcb_en(s0_srcb_en), .s0_lat(s0_lat),
      .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_dst_en(s1_dst_en),
      .s1_srca(s1_srca), .s1_srca_en(s1_srca_en), .s1_srcb(s1_srcb),
      .s1_srcb_en(s1_srcb_en), .s1_lat(s1_lat),
      .grant0(grant0), .grant1(grant1), .consumed(consumed)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 0;
   exp_t  q[$];
   int    mc[NR];

   function automatic desc_t mk(bit [1:0] cls, bit de, bit [3:0] dst, bit [2:0] lat,
                                bit ae, bit [3:0] sa, bit be, bit [3:0] sb);
      desc_t d;
      d.vld = 1; d.cls = cls; d.de = de; d.dst = dst; d.lat = lat;
      d.ae = ae; d.sa = sa; d.be = be; d.sb = sb;
      return d;
   endfunction

   function automatic desc_t nop();
      desc_t d;
      d.vld = 0; d.cls = 0; d.de = 0; d.dst = 0; d.lat = 1;
      d.ae = 0; d.sa = 0; d.be = 0; d.sb = 0;
      return d;
   endfunction

   function automatic bit rdy(bit en, bit [3:0] r);
      return !en || (mc[r] <= 1);
   endfunction

   function automatic bit clear(desc_t d);
      return rdy(d.ae, d.sa) && rdy(d.be, d.sb) && (!d.de || (mc[d.dst] < int'(d.lat)));
   endfunction

   task automatic apply(desc_t a, desc_t b, bit fl, string tag);
      exp_t e;
      @(negedge clk);
      flush = fl;
      s0_vld = a.vld; s0_cls = a.cls; s0_dst = a.dst; s0_dst_en = a.de;
      s0_srca = a.sa; s0_srca_en = a.ae; s0_srcb = a.sb; s0_srcb_en = a.be;
      s0_lat = a.lat;
      s1_vld = b.vld; s1_cls = b.cls; s1_dst = b.dst; s1_dst_en = b.de;
      s1_srca = b.sa; s1_srca_en = b.ae; s1_srcb = b.sb; s1_srcb_en = b.be;
      s1_lat = b.lat;
      e.g0 = !fl && a.vld && clear(a);
      e.g1 = e.g0 && b.vld && clear(b) && (b.cls != 2'b01) &&
             !(a.cls == 2'b10 && b.cls == 2'b10) &&
             !(a.de && ((b.ae && b.sa == a.dst) || (b.be && b.sb == a.dst) ||
                        (b.de && b.dst == a.dst)));
      e.tag = tag;
      q.push_back(e);
      if (fl) begin
         foreach (mc[r]) mc[r] = 0;
      end else begin
         foreach (mc[r]) if (mc[r] > 0) mc[r]--;
         if (e.g0 && a.de) mc[a.dst] = a.lat;
         if (e.g1 && b.de) mc[b.dst] = b.lat;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) apply(nop(), nop(), 0, "R9 idle");
   endtask

   // monitor: compares each applied vector before the next rising edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            vectors++;
            if (grant0 !== e.g0 || grant1 !== e.g1) begin
               miscompares++;
               $display("FAIL %s: grants=%b%b expected=%b%b", e.tag, grant0, grant1, e.g0, e.g1);
            end
            if (consumed !== 2'(e.g0) + 2'(e.g1)) begin
               miscompares++;
               $display("FAIL R9 (%s): consumed=%0d expected=%0d", e.tag, consumed,
                        2'(e.g0) + 2'(e.g1));
            end
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog: run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      foreach (mc[r]) mc[r] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 / R1: every register ready after reset, independent pair issues
      apply(mk(2'b00, 1, 4'd3, 3'd1, 1, 4'd1, 1, 4'd2),
            mk(2'b00, 1, 4'd6, 3'd1, 1, 4'd4, 1, 4'd5), 0, "R10 R1 pair after reset");
      idle(2);

      // R3: read-after-write with latency 4 and forwarding level 1
      apply(mk(2'b00, 1, 4'd1, 3'd4, 0, 4'd0, 0, 4'd0), nop(), 0, "R3 producer");
      for (int i = 0; i < 4; i++)
         apply(mk(2'b00, 1, 4'd7, 3'd1, 1, 4'd1, 0, 4'd0), nop(), 0, "R3 consumer wait");
      // R3: disabled source is ignored
      apply(mk(2'b00, 1, 4'd14, 3'd7, 0, 4'd0, 0, 4'd0), nop(), 0, "R3 producer r14");
      apply(mk(2'b00, 1, 4'd2, 3'd1, 0, 4'd14, 0, 4'd14), nop(), 0, "R3 disabled sources");
      idle(7);

      // R2: stalled slot 0 holds back an independent slot 1
      apply(mk(2'b00, 1, 4'd8, 3'd5, 0, 4'd0, 0, 4'd0), nop(), 0, "R2 producer");
      apply(mk(2'b00, 1, 4'd9, 3'd1, 1, 4'd8, 0, 4'd0),
            mk(2'b00, 1, 4'd10, 3'd1, 1, 4'd11, 0, 4'd0), 0, "R2 in-order hold");
      idle(5);
      apply(nop(), mk(2'b00, 1, 4'd10, 3'd1, 0, 4'd0, 0, 4'd0), 0, "R2 slot0 empty");

      // R5: multiply only on pipe0
      apply(mk(2'b00, 1, 4'd3, 3'd1, 0, 4'd0, 0, 4'd0),
            mk(2'b01, 1, 4'd4, 3'd3, 1, 4'd5, 0, 4'd0), 0, "R5 mul on slot1");
      apply(mk(2'b01, 1, 4'd4, 3'd3, 1, 4'd5, 0, 4'd0),
            mk(2'b00, 1, 4'd3, 3'd1, 0, 4'd0, 0, 4'd0), 0, "R5 mul on slot0");
      idle(3);

      // R6: one load/store per pair
      apply(mk(2'b10, 1, 4'd5, 3'd3, 1, 4'd1, 0, 4'd0),
            mk(2'b10, 1, 4'd6, 3'd3, 1, 4'd2, 0, 4'd0), 0, "R6 ls ls");
      idle(3);
      apply(mk(2'b10, 1, 4'd5, 3'd3, 1, 4'd1, 0, 4'd0),
            mk(2'b00, 1, 4'd6, 3'd1, 1, 4'd2, 0, 4'd0), 0, "R6 ls alu");
      idle(3);

      // R7: dependence inside the pair
      apply(mk(2'b00, 1, 4'd9, 3'd1, 0, 4'd0, 0, 4'd0),
            mk(2'b00, 1, 4'd11, 3'd1, 0, 4'd0, 1, 4'd9), 0, "R7 pair read");
      idle(2);
      apply(mk(2'b00, 1, 4'd10, 3'd1, 0, 4'd0, 0, 4'd0),
            mk(2'b00, 1, 4'd10, 3'd2, 0, 4'd0, 0, 4'd0), 0, "R7 pair same dest");
      idle(2);
      apply(mk(2'b00, 0, 4'd11, 3'd1, 0, 4'd0, 0, 4'd0),
            mk(2'b00, 1, 4'd12, 3'd1, 1, 4'd11, 0, 4'd0), 0, "R7 no dest enable");
      idle(2);

      // R4: write-after-write ordering
      apply(mk(2'b00, 1, 4'd12, 3'd6, 0, 4'd0, 0, 4'd0), nop(), 0, "R4 long write");
      apply(mk(2'b00, 1, 4'd12, 3'd2, 0, 4'd0, 0, 4'd0), nop(), 0, "R4 short write stalls");
      apply(mk(2'b00, 1, 4'd12, 3'd7, 0, 4'd0, 0, 4'd0), nop(), 0, "R4 longer write ok");
      idle(8);

      // R8: flush withholds grants and clears the scoreboard
      apply(mk(2'b00, 1, 4'd13, 3'd7, 0, 4'd0, 0, 4'd0), nop(), 0, "R8 producer");
      apply(mk(2'b00, 1, 4'd1, 3'd1, 0, 4'd0, 0, 4'd0),
            mk(2'b00, 1, 4'd2, 3'd1, 0, 4'd0, 0, 4'd0), 1, "R8 flush cycle");
      apply(mk(2'b00, 1, 4'd3, 3'd1, 1, 4'd13, 0, 4'd0),
            mk(2'b00, 1, 4'd4, 3'd1, 0, 4'd0, 1, 4'd13), 0, "R8 after flush");
      idle(2);

      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule